// File: doc/BRIEF.md
# Character LCD Nibble-Mode Read Sequencer

This block fetches one byte from a character-LCD controller over a four-line data bus. It is used when the display is wired in nibble mode. A host pulses a request and gives a select flag. With the flag high the block reads the controller's data register. With the flag low it reads the status byte, which holds the busy flag and the address counter. The block then runs the whole bus transaction on its own. It drives the register-select line and raises read/write. It releases the data lines to input, then issues two enable pulses with a timed low gap between them. It returns the reassembled byte with a one-cycle done strobe.

All strobe timings are parameters counted in clock cycles: the setup before the first enable, the enable-high width and the enable-low gap. The bus is read through a multi-flop synchronizer. Each enable-high window is therefore stretched by the synchronizer depth, so that the value captured at the end of the window was already present on the pins while enable was high. The first pulse yields bits 7:4 and the second yields bits 3:0. After a one-cycle hold, read/write falls and the data lines return to output.

Top module: `lcd_nibble_reader`

## Requirements
- R1: After reset, enable and read/write are low, the data-direction output is 1 (host drives the bus), busy and done are low and the read byte is 0x00.
- R2: Register select takes the value of `sel_data_i` at request acceptance (1 = data register, 0 = busy flag and address counter) and does not change while busy is high.
- R3: From the cycle after acceptance, read/write is high and the direction output is 0 (bus released to input), for exactly SETUP_CYC cycles before the first enable rise; whenever enable is high, read/write is high and direction is 0.
- R4: The nibble present on the bus during the first enable pulse becomes bits 7:4 of `rdata_o`, and the nibble during the second pulse becomes bits 3:0.
- R5: Each enable pulse stays high for exactly EH_CYC + SYNC_STAGES cycles.
- R6: Enable stays low for exactly EL_CYC cycles between the two pulses.
- R7: One cycle after the second pulse ends, done is high for exactly one cycle. In that cycle busy is low, read/write is low, direction is 1 and `rdata_o` holds the byte.
- R8: Busy is high for exactly SETUP_CYC + 2*(EH_CYC+SYNC_STAGES) + EL_CYC + 1 cycles per transaction.
- R9: A request that arrives while busy is high has no effect: select does not change, and no further transaction follows the done strobe.
- R10: Exactly two enable pulses occur per transaction.
- R11: Bus values present while enable is low do not reach `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, taken when not busy |
| sel_data_i | input | 1 | 1 = data register, 0 = busy flag and address counter |
| busy_o | output | 1 | High from acceptance until the done strobe |
| done_o | output | 1 | One-cycle strobe, byte valid |
| rdata_o | output | 8 | Byte read from the display controller |
| lcd_rs_o | output | 1 | Register select |
| lcd_rw_o | output | 1 | Read/write, high for read |
| lcd_en_o | output | 1 | Enable strobe |
| lcd_drive_o | output | 1 | Data-line direction, 1 = host drives, 0 = input |
| lcd_db_i | input | 4 | Data nibble from the display pins |

## Verification
A display model answers each enable pulse with the correct half of a byte chosen per transaction. While enable is low it puts random noise on the lines, so any capture outside a high window shows up as a wrong byte. Transactions alternate between data and status reads with random bytes. Directed values 0x00, 0xFF, 0xA5 and 0x5A tell nibble order and bit swaps apart. Select is flipped in some requests made during busy, which separates a design that ignores such requests from one that restarts or latches the new select. Pulse widths, gap, setup and busy length are measured at the pins in every transaction.

// File: rtl/lcd_rd_pkg.sv
package lcd_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_EHI,
        ST_ELO,
        ST_REL
    } rd_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcd_rd_sync.sv
module lcd_rd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] pipe_q;
            logic [STAGES-1:0][W-1:0] pipe_d;

            always_comb begin
                pipe_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= pipe_d;
            end

            assign dout = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lcd_rd_capture.sv
module lcd_rd_capture #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_hi,
    input  logic               take_lo,
    input  logic [NIB_W-1:0]   nib,
    output logic [2*NIB_W-1:0] byte_o
);
    logic [NIB_W-1:0]   hi_d, hi_q;
    logic [2*NIB_W-1:0] byte_d, byte_q;

    always_comb begin
        hi_d   = hi_q;
        byte_d = byte_q;
        if (take_hi) hi_d   = nib;
        if (take_lo) byte_d = {hi_q, nib};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            byte_q <= '0;
        end else begin
            hi_q   <= hi_d;
            byte_q <= byte_d;
        end
    end

    assign byte_o = byte_q;
endmodule

// File: rtl/lcd_nibble_reader.sv
module lcd_nibble_reader
    import lcd_rd_pkg::*;
#(
    parameter int SETUP_CYC   = 4,
    parameter int EH_CYC      = 25,
    parameter int EL_CYC      = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       sel_data_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rdata_o,
    output logic       lcd_rs_o,
    output logic       lcd_rw_o,
    output logic       lcd_en_o,
    output logic       lcd_drive_o,
    input  logic [3:0] lcd_db_i
);
    localparam int NIB_W   = 4;
    localparam int EH_TOT  = EH_CYC + SYNC_STAGES;
    localparam int CNT_MAX = max3(SETUP_CYC, EH_TOT, EL_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int RW_W    = CW + 1;

    typedef struct packed {
        rd_state_t     st;
        logic [CW-1:0] cnt;
        logic          second;
        logic          rs;
        logic          rw;
        logic          en;
        logic          drive;
        logic          busy;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic take_hi, take_lo;
    logic [NIB_W-1:0] nib_sync;

    lcd_rd_sync #(.W(NIB_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lcd_db_i),
        .dout (nib_sync)
    );

    lcd_rd_capture #(.NIB_W(NIB_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_hi(take_hi),
        .take_lo(take_lo),
        .nib    (nib_sync),
        .byte_o (rdata_o)
    );

    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.done = 1'b0;
        take_hi = 1'b0;
        take_lo = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st     = ST_SETUP;
                    ctl_d.cnt    = CW'(SETUP_CYC - 1);
                    ctl_d.rs     = sel_data_i;
                    ctl_d.rw     = 1'b1;
                    ctl_d.drive  = 1'b0;
                    ctl_d.busy   = 1'b1;
                    ctl_d.second = 1'b0;
                end
            end
            ST_SETUP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_EHI;
                    ctl_d.en  = 1'b1;
                    ctl_d.cnt = CW'(EH_TOT - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_EHI: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.en = 1'b0;
                    take_hi  = !ctl_q.second;
                    take_lo  = ctl_q.second;
                    if (ctl_q.second) begin
                        ctl_d.st = ST_REL;
                    end else begin
                        ctl_d.st  = ST_ELO;
                        ctl_d.cnt = CW'(EL_CYC - 1);
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_ELO: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st     = ST_EHI;
                    ctl_d.en     = 1'b1;
                    ctl_d.second = 1'b1;
                    ctl_d.cnt    = CW'(EH_TOT - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_REL: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.rw    = 1'b0;
                ctl_d.drive = 1'b1;
                ctl_d.busy  = 1'b0;
                ctl_d.done  = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.drive <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = ctl_q.busy;
    assign done_o      = ctl_q.done;
    assign lcd_rs_o    = ctl_q.rs;
    assign lcd_rw_o    = ctl_q.rw;
    assign lcd_en_o    = ctl_q.en;
    assign lcd_drive_o = ctl_q.drive;

    // Run-length counters that support the timing properties below
    logic [RW_W-1:0] hi_run_q, lo_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= lcd_en_o ? hi_run_q + 1'b1 : '0;
            lo_run_q <= lcd_en_o ? '0 : lo_run_q + 1'b1;
        end
    end

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!lcd_en_o && !lcd_rw_o && lcd_drive_o));

    p_rs_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(lcd_rs_o));

    p_read_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en_o |-> (lcd_rw_o && !lcd_drive_o));

    p_en_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en_o) |-> (hi_run_q == RW_W'(EH_TOT)));

    p_en_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_en_o) && ctl_q.second) |-> (lo_run_q == RW_W'(EL_CYC)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !lcd_rw_o && lcd_drive_o && $past(busy_o)));
endmodule

// File: tb/lcd_nibble_reader_test.sv
`timescale 1ns/1ps
module lcd_nibble_reader_test;
    localparam int SETUP = 2;
    localparam int EH    = 3;
    localparam int EL    = 6;
    localparam int SS    = 2;
    localparam int EHT   = EH + SS;
    localparam int BUSY_LEN = SETUP + 2*EHT + EL + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       sel = 1'b0;
    logic       busy, done, rs, rw, en, drive;
    logic [7:0] rdata;
    logic [3:0] db = 4'h0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] data_reg = 8'h00;
    logic [7:0] stat_reg = 8'h00;
    int  pulse_idx = 0;
    logic en_prev = 1'b0;

    always #5 clk = ~clk;

    lcd_nibble_reader #(
        .SETUP_CYC(SETUP), .EH_CYC(EH), .EL_CYC(EL), .SYNC_STAGES(SS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sel_data_i(sel),
        .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .lcd_rs_o(rs), .lcd_rw_o(rw), .lcd_en_o(en), .lcd_drive_o(drive),
        .lcd_db_i(db)
    );

    // Display model: valid nibble while enable is high, noise otherwise
    always @(negedge clk) begin
        if (en_prev && !en) pulse_idx <= pulse_idx + 1;
        en_prev <= en;
        if (en) begin
            logic [7:0] src;
            src = rs ? data_reg : stat_reg;
            db <= (pulse_idx == 0) ? src[7:4] : src[3:0];
        end else begin
            db <= 4'($urandom);
        end
    end

    function automatic logic [7:0] expect_byte(input bit s, input logic [7:0] d,
                                               input logic [7:0] st);
        return s ? d : st;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic do_read(input bit s, input logic [7:0] d, input logic [7:0] st,
                           input bit inject);
        int busy_cnt = 0, rises = 0, setup_cnt = 0, wd = 0;
        int hi_w = 0, lo_w = 0;
        bit seen_en = 0, rs_bad = 0, dir_bad = 0, w_bad = 0, g_bad = 0, en_last = 0;
        data_reg = d;
        stat_reg = st;
        @(negedge clk);
        pulse_idx = 0;
        req = 1'b1;
        sel = s;
        @(negedge clk);
        req = 1'b0;
        while (!done && wd < 1000) begin
            wd++;
            if (busy) busy_cnt++;
            if (busy && rs !== s) rs_bad = 1;
            if (en && (!rw || drive)) dir_bad = 1;
            if (busy && !en && !seen_en) begin
                setup_cnt++;
                if (!rw || drive) dir_bad = 1;
            end
            if (en && !en_last) begin
                rises++;
                if (seen_en && lo_w != EL) g_bad = 1;
                seen_en = 1;
                hi_w = 0;
            end
            if (!en && en_last && hi_w != EHT) w_bad = 1;
            if (en) hi_w++;
            if (!en && en_last) lo_w = 0;
            if (!en) lo_w++;
            en_last = en;
            if (inject && busy_cnt == 4) begin
                req = 1'b1;
                sel = ~s;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        req = 1'b0;
        chk(wd < 1000, "R7 done strobe reached", wd, 0);
        chk(rdata == expect_byte(s, d, st), s ? "R4/R11 data read byte" : "R4/R11 status read byte",
            rdata, expect_byte(s, d, st));
        chk(!rs_bad, "R2 select held", rs, s);
        chk(!dir_bad, "R3 rw high and bus released", {rw, drive}, 2);
        chk(setup_cnt == SETUP, "R3 setup before enable", setup_cnt, SETUP);
        chk(!w_bad, "R5 enable width", hi_w, EHT);
        chk(!g_bad, "R6 enable gap", lo_w, EL);
        chk(rises == 2, "R10 pulse count", rises, 2);
        chk(busy_cnt == BUSY_LEN, "R8 busy length", busy_cnt, BUSY_LEN);
        chk(done && !busy && !rw && drive, "R7 release at done", {done, busy, rw, drive}, 4'b1001);
        @(negedge clk);
        chk(!done, "R7 single done", done, 0);
        if (inject) begin
            @(negedge clk);
            chk(!busy && !en, "R9 request during busy ignored", busy, 0);
            chk(rs == s, "R9 select unchanged", rs, s);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!en && !rw && drive && !busy && !done && rdata == 8'h00,
            "R1 reset state", {en, rw, drive, busy, done}, 5'b00100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!en && !rw && drive && !busy && !done && rdata == 8'h00,
            "R1 idle after reset", rdata, 0);
        do_read(1'b1, 8'h00, 8'hFF, 1'b0);
        do_read(1'b1, 8'hFF, 8'h00, 1'b0);
        do_read(1'b0, 8'h5A, 8'hA5, 1'b0);
        do_read(1'b1, 8'hA5, 8'h5A, 1'b1);
        do_read(1'b0, 8'h11, 8'h80, 1'b1);
        for (int i = 0; i < 40; i++) begin
            do_read(1'($urandom), 8'($urandom), 8'($urandom), (i % 5) == 0);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule